// File: doc/BRIEF.md
# Duty-Cycle Transition Search Engine

The block calibrates one duty-cycle adjuster by a linear search. A start pulse captures a seed code and a side-select bit. The block then drives the seed onto the adjuster with the correction enable raised, waits a settling time, and samples the single-bit compare output of an external distortion detector. That first sample fixes both the direction of the search and the compare value that ends it. A 0 means the code must rise until the detector reports 1. A 1 means the code must fall until the detector reports 0.

After every step of one code, the block waits the settling time before it samples again. After a sample that does not end the search, it waits a further gap before the next step. The search stops with success when the sampled bit equals the expected value, and it reports the code in effect at that moment. It stops with a fail flag when the code reaches the rail in the chosen direction. The settling time and the gap are parameters in clock cycles. For example, 100 ns at 200 MHz is 20 cycles.

Top module: `duty_search_top`

## Requirements
- R1: During and after reset the outputs read adj_o = 0, corr_en_o = 0, busy_o = 0, done_o = 0, fail_o = 0 and result_o = 0.
- R2: A start pulse while idle loads seed_i onto adj_o and captures side_i onto side_o at the next clock edge. From that edge until the search ends, busy_o and corr_en_o are 1.
- R3: The first compare sample is taken SETTLE_CYC cycles after the seed is loaded. A sampled 0 selects upward stepping with an expected end value of 1. A sampled 1 selects downward stepping with an expected end value of 0.
- R4: Each step changes adj_o by exactly one code. The first step follows the seed sample at once. Each later sample comes SETTLE_CYC cycles after its step, and each later step comes GAP_CYC cycles after a non-ending sample. With k steps the search therefore ends SETTLE_CYC + k*SETTLE_CYC + (k-1)*GAP_CYC edges after the start edge (SETTLE_CYC when k = 0).
- R5: When a sample after a step equals the expected value and the code is not at the rail, done_o pulses with fail_o = 0, and result_o holds the current adjust code.
- R6: When a step lands on the rail (all ones going up, zero going down), the search ends at the following sample with fail_o = 1 and result_o equal to the rail code. This holds even when the compare bit flips on that same sample.
- R7: When the seed already sits on the rail in the direction chosen by the first sample, the search ends at that sample with fail_o = 1 and no step is made.
- R8: done_o is high for exactly one cycle per search. result_o and fail_o change only in the done cycle and hold their values until the next done.
- R9: A start pulse while busy_o is 1 has no effect on the running search, on its result, or on side_o.
- R10: With ADJ_W = 7 the adjust code is 7 bits wide and the upward rail is 127.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start a search (ignored while busy) |
| seed_i | input | ADJ_W | Starting adjust code |
| side_i | input | 1 | Side select captured at start |
| cmp_i | input | 1 | Compare output of the distortion detector |
| adj_o | output | ADJ_W | Adjust code driven to the detector |
| corr_en_o | output | 1 | Correction enable for the detector |
| side_o | output | 1 | Captured side select driven to the detector |
| busy_o | output | 1 | Search in progress |
| done_o | output | 1 | One-cycle end-of-search pulse |
| fail_o | output | 1 | Search hit the rail |
| result_o | output | ADJ_W | Adjust code at the end of the search |

## Verification
Arrival at the rail and a flip of the compare bit can fall on the same sample. The bench provokes this by placing the detector threshold exactly on the rail: a threshold of 255 with an upward search, and a threshold of 1 with a downward search, where code 0 already reads as 0. A correct design reports a fail with the rail code, because the rail takes priority over the match. A second collision, a start pulse arriving during a running search, is judged by checking that result, side and end time all match a search that had no second pulse.

// File: rtl/dse_pkg.sv
package dse_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SEED,
    ST_PROBE,
    ST_GAP
  } dse_state_e;

  function automatic int unsigned dse_max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/dse_timer.sv
module dse_timer #(
  parameter int unsigned CW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [CW-1:0] load_val_i,
  output logic          zero_o
);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load_i)
      cnt_d = load_val_i;
    else if (cnt_q != '0)
      cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign zero_o = (cnt_q == '0);

  // R4: a freshly loaded wait is never seen as expired on the next cycle unless loaded with 0
  a_r4_timer_load: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && load_val_i != '0) |=> !zero_o);

endmodule

// File: rtl/dse_adjuster.sv
module dse_adjuster #(
  parameter int unsigned AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [AW-1:0] seed_i,
  input  logic          side_i,
  input  logic          step_i,
  input  logic          down_i,
  output logic [AW-1:0] code_o,
  output logic          side_o,
  output logic          at_top_o,
  output logic          at_bot_o
);

  localparam logic [AW-1:0] CODE_MAX = {AW{1'b1}};

  logic [AW-1:0] code_q, code_d;
  logic          side_q, side_d;

  always_comb begin
    code_d = code_q;
    side_d = side_q;
    if (load_i) begin
      code_d = seed_i;
      side_d = side_i;
    end else if (step_i) begin
      code_d = down_i ? (code_q - 1'b1) : (code_q + 1'b1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= '0;
      side_q <= 1'b0;
    end else begin
      code_q <= code_d;
      side_q <= side_d;
    end
  end

  assign code_o   = code_q;
  assign side_o   = side_q;
  assign at_top_o = (code_q == CODE_MAX);
  assign at_bot_o = (code_q == '0);

  // R4: outside a seed load the code moves by at most one per cycle
  a_r4_unit_step: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i |=> (code_q == $past(code_q) ||
                 code_q == $past(code_q) + 1'b1 ||
                 code_q == $past(code_q) - 1'b1));

  // R6: a step never wraps past a rail
  a_r6_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && step_i && down_i && code_q == '0) |=> 1'b0);

endmodule

// File: rtl/dse_ctrl.sv
module dse_ctrl
  import dse_pkg::*;
#(
  parameter int unsigned AW         = 8,
  parameter int unsigned CW         = 5,
  parameter int unsigned SETTLE_CYC = 20,
  parameter int unsigned GAP_CYC    = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          cmp_i,
  input  logic          tmr_zero_i,
  input  logic          at_top_i,
  input  logic          at_bot_i,
  input  logic [AW-1:0] code_i,
  output logic          ld_seed_o,
  output logic          step_o,
  output logic          down_o,
  output logic          tmr_load_o,
  output logic [CW-1:0] tmr_val_o,
  output logic          busy_o,
  output logic          done_o,
  output logic          fail_o,
  output logic [AW-1:0] result_o
);

  localparam logic [CW-1:0] SETTLE_LD = CW'(SETTLE_CYC - 1);
  localparam logic [CW-1:0] GAP_LD    = CW'(GAP_CYC - 1);

  dse_state_e    state_q, state_d;
  logic          dir_q, dir_d;
  logic          done_q, done_d;
  logic          fail_q, fail_d;
  logic [AW-1:0] result_q, result_d;
  logic          rail_now;

  always_comb begin
    state_d    = state_q;
    dir_d      = dir_q;
    done_d     = 1'b0;
    fail_d     = fail_q;
    result_d   = result_q;
    ld_seed_o  = 1'b0;
    step_o     = 1'b0;
    down_o     = dir_q;
    tmr_load_o = 1'b0;
    tmr_val_o  = SETTLE_LD;
    rail_now   = 1'b0;

    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          ld_seed_o  = 1'b1;
          tmr_load_o = 1'b1;
          tmr_val_o  = SETTLE_LD;
          state_d    = ST_SEED;
        end
      end

      ST_SEED: begin
        if (tmr_zero_i) begin
          dir_d    = cmp_i;
          down_o   = cmp_i;
          rail_now = cmp_i ? at_bot_i : at_top_i;
          if (rail_now) begin
            done_d   = 1'b1;
            fail_d   = 1'b1;
            result_d = code_i;
            state_d  = ST_IDLE;
          end else begin
            step_o     = 1'b1;
            tmr_load_o = 1'b1;
            tmr_val_o  = SETTLE_LD;
            state_d    = ST_PROBE;
          end
        end
      end

      ST_PROBE: begin
        if (tmr_zero_i) begin
          rail_now = dir_q ? at_bot_i : at_top_i;
          if (rail_now) begin
            done_d   = 1'b1;
            fail_d   = 1'b1;
            result_d = code_i;
            state_d  = ST_IDLE;
          end else if (cmp_i == !dir_q) begin
            done_d   = 1'b1;
            fail_d   = 1'b0;
            result_d = code_i;
            state_d  = ST_IDLE;
          end else begin
            tmr_load_o = 1'b1;
            tmr_val_o  = GAP_LD;
            state_d    = ST_GAP;
          end
        end
      end

      ST_GAP: begin
        if (tmr_zero_i) begin
          step_o     = 1'b1;
          tmr_load_o = 1'b1;
          tmr_val_o  = SETTLE_LD;
          state_d    = ST_PROBE;
        end
      end

      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      dir_q    <= 1'b0;
      done_q   <= 1'b0;
      fail_q   <= 1'b0;
      result_q <= '0;
    end else begin
      state_q  <= state_d;
      dir_q    <= dir_d;
      done_q   <= done_d;
      fail_q   <= fail_d;
      result_q <= result_d;
    end
  end

  assign busy_o   = (state_q != ST_IDLE);
  assign done_o   = done_q;
  assign fail_o   = fail_q;
  assign result_o = result_q;

  // R8: done lasts one cycle
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  // R8: outcome registers move only together with done
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !done_q |-> ($stable(result_q) && $stable(fail_q)));

  // R6: a failing search always ends on a rail code
  a_r6_fail_on_rail: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && fail_q) |-> (result_q == '0 || result_q == {AW{1'b1}}));

  // R5: a successful search never reports the rail in its own direction
  a_r5_success_off_rail: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && !fail_q) |-> (result_q != (dir_q ? {AW{1'b0}} : {AW{1'b1}})));

  // R9: a busy engine stays busy until it reports done
  a_r9_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i && !tmr_zero_i) |=> busy_o);

endmodule

// File: rtl/duty_search_top.sv
module duty_search_top #(
  parameter int unsigned ADJ_W      = 8,
  parameter int unsigned SETTLE_CYC = 20,
  parameter int unsigned GAP_CYC    = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [ADJ_W-1:0] seed_i,
  input  logic             side_i,
  input  logic             cmp_i,
  output logic [ADJ_W-1:0] adj_o,
  output logic             corr_en_o,
  output logic             side_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             fail_o,
  output logic [ADJ_W-1:0] result_o
);

  localparam int unsigned WAIT_MAX = dse_pkg::dse_max2(SETTLE_CYC, GAP_CYC);
  localparam int unsigned CW       = $clog2(WAIT_MAX + 1);

  logic          ld_seed, step, down, tmr_load, tmr_zero, at_top, at_bot;
  logic [CW-1:0] tmr_val;

  dse_timer #(.CW(CW)) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (tmr_load),
    .load_val_i (tmr_val),
    .zero_o     (tmr_zero)
  );

  dse_adjuster #(.AW(ADJ_W)) u_adj (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_i   (ld_seed),
    .seed_i   (seed_i),
    .side_i   (side_i),
    .step_i   (step),
    .down_i   (down),
    .code_o   (adj_o),
    .side_o   (side_o),
    .at_top_o (at_top),
    .at_bot_o (at_bot)
  );

  dse_ctrl #(
    .AW         (ADJ_W),
    .CW         (CW),
    .SETTLE_CYC (SETTLE_CYC),
    .GAP_CYC    (GAP_CYC)
  ) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .cmp_i      (cmp_i),
    .tmr_zero_i (tmr_zero),
    .at_top_i   (at_top),
    .at_bot_i   (at_bot),
    .code_i     (adj_o),
    .ld_seed_o  (ld_seed),
    .step_o     (step),
    .down_o     (down),
    .tmr_load_o (tmr_load),
    .tmr_val_o  (tmr_val),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .fail_o     (fail_o),
    .result_o   (result_o)
  );

  assign corr_en_o = busy_o;

  // R2: an accepted start loads the seed and side and raises busy
  a_r2_launch: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o) |=> (busy_o && corr_en_o &&
                              adj_o == $past(seed_i) && side_o == $past(side_i)));

  // R9: side select is frozen during a search
  a_r9_side_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && $past(busy_o)) |-> $stable(side_o));

endmodule

// File: tb/sim_duty_search_top.sv
module sim_duty_search_top;

  localparam int unsigned S = 3;
  localparam int unsigned G = 2;

  logic       clk;
  logic       rst_n;

  logic       st0, side0;
  logic [7:0] seed0;
  logic [8:0] thr0;
  logic       cmp0;
  logic [7:0] adj0, res0;
  logic       corr0, sideo0, busy0, done0, fail0;

  logic       st1, side1;
  logic [6:0] seed1;
  logic [8:0] thr1;
  logic       cmp1;
  logic [6:0] adj1, res1;
  logic       corr1, sideo1, busy1, done1, fail1;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  assign cmp0 = ({1'b0, adj0} >= thr0);
  assign cmp1 = ({2'b0, adj1} >= thr1);

  duty_search_top #(.ADJ_W(8), .SETTLE_CYC(S), .GAP_CYC(G)) u0 (
    .clk(clk), .rst_n(rst_n), .start_i(st0), .seed_i(seed0), .side_i(side0),
    .cmp_i(cmp0), .adj_o(adj0), .corr_en_o(corr0), .side_o(sideo0),
    .busy_o(busy0), .done_o(done0), .fail_o(fail0), .result_o(res0));

  duty_search_top #(.ADJ_W(7), .SETTLE_CYC(S), .GAP_CYC(G)) u1 (
    .clk(clk), .rst_n(rst_n), .start_i(st1), .seed_i(seed1), .side_i(side1),
    .cmp_i(cmp1), .adj_o(adj1), .corr_en_o(corr1), .side_o(sideo1),
    .busy_o(busy1), .done_o(done1), .fail_o(fail1), .result_o(res1));

  initial clk = 1'b0;
  always #4 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      fails = fails + 1;
      $display("FAIL watchdog: actual %0d cycles, expected under 150000", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks = checks + 1;
    if (!ok) begin
      fails = fails + 1;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // seed[17:10], side[9], threshold[8:0]
  localparam int NV = 11;
  localparam logic [17:0] VEC [NV] = '{
    {8'd128, 1'b0, 9'd140},
    {8'd128, 1'b1, 9'd100},
    {8'd10,  1'b0, 9'd11 },
    {8'd10,  1'b1, 9'd10 },
    {8'd0,   1'b0, 9'd0  },
    {8'd255, 1'b1, 9'd256},
    {8'd250, 1'b0, 9'd255},
    {8'd5,   1'b1, 9'd1  },
    {8'd3,   1'b0, 9'd2  },
    {8'd200, 1'b1, 9'd256},
    {8'd254, 1'b0, 9'd255}
  };

  task automatic run(input bit wide, input int seed, input int side,
                     input int thr, input int poke);
    int maxv, r, k, lat, n;
    bit xf, up, got_done, ok;
    int sres, sfail;
    maxv = wide ? 255 : 127;
    up   = !(seed >= thr);
    if (up) begin
      if (seed == maxv)        begin r = maxv; xf = 1; end
      else if (thr < maxv)     begin r = thr;  xf = 0; end
      else                     begin r = maxv; xf = 1; end
      k = r - seed;
    end else begin
      if (seed == 0)           begin r = 0;       xf = 1; end
      else if (thr >= 2)       begin r = thr - 1; xf = 0; end
      else                     begin r = 0;       xf = 1; end
      k = seed - r;
    end
    lat = (k == 0) ? S : (S + k * S + (k - 1) * G);

    @(negedge clk);
    if (wide) begin thr0 = 9'(thr); seed0 = 8'(seed); side0 = side[0]; st0 = 1'b1; end
    else      begin thr1 = 9'(thr); seed1 = 7'(seed); side1 = side[0]; st1 = 1'b1; end
    @(posedge clk);
    #1;
    // R2: seed, side, busy and enable after the start edge
    if (wide) ok = (adj0 == 8'(seed)) && busy0 && corr0 && (sideo0 == side[0]);
    else      ok = (adj1 == 7'(seed)) && busy1 && corr1 && (sideo1 == side[0]);
    chk(ok, "R2 launch", wide ? int'(adj0) : int'(adj1), seed);
    @(negedge clk);
    st0 = 1'b0; st1 = 1'b0;

    n = 0; got_done = 0;
    while (!got_done && n < 5000) begin
      @(posedge clk);
      n = n + 1;
      #1;
      st0 = 1'b0; st1 = 1'b0;
      got_done = wide ? done0 : done1;
      if (!got_done && poke != 0 && n == poke) begin
        // R9: second start during the search
        if (wide) begin seed0 = 8'(seed) ^ 8'h55; side0 = ~side[0]; st0 = 1'b1; end
        else      begin seed1 = 7'(seed) ^ 7'h2a; side1 = ~side[0]; st1 = 1'b1; end
      end
    end
    st0 = 1'b0; st1 = 1'b0;
    chk(got_done, "R8 done seen", int'(got_done), 1);
    sres  = wide ? int'(res0)  : int'(res1);
    sfail = wide ? int'(fail0) : int'(fail1);
    // R3 direction and R5 success code, R6/R7 rail handling, R10 narrow rail
    chk(sres == r, wide ? "R5 R6 R3 result" : "R10 result", sres, r);
    chk(sfail == int'(xf), xf ? "R6 R7 fail flag" : "R5 fail flag", sfail, int'(xf));
    // R4 timing, R7 no step when seed is on the rail
    chk(n == lat, (k == 0) ? "R7 R3 latency" : "R4 latency", n, lat);
    chk((wide ? sideo0 : sideo1) == side[0], "R9 side kept", int'(wide ? sideo0 : sideo1), side);
    @(posedge clk);
    #1;
    chk(!(wide ? done0 : done1) && !(wide ? busy0 : busy1), "R8 done single cycle",
        int'(wide ? done0 : done1), 0);
    repeat (4) @(posedge clk);
    #1;
    chk((wide ? int'(res0) : int'(res1)) == sres && (wide ? int'(fail0) : int'(fail1)) == sfail,
        "R8 outcome held", wide ? int'(res0) : int'(res1), sres);
  endtask

  initial begin
    rst_n = 1'b0;
    st0 = 1'b0; side0 = 1'b0; seed0 = '0; thr0 = 9'd0;
    st1 = 1'b0; side1 = 1'b0; seed1 = '0; thr1 = 9'd0;
    repeat (3) @(posedge clk);
    #1;
    // R1: reset values
    chk(adj0 == 8'd0 && res0 == 8'd0, "R1 codes", int'(adj0), 0);
    chk(!busy0 && !corr0, "R1 busy", int'(busy0), 0);
    chk(!done0 && !fail0, "R1 done fail", int'(done0), 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(posedge clk);
    #1;
    chk(adj0 == 8'd0 && !busy0 && !done0 && !fail0 && res0 == 8'd0, "R1 after release",
        int'(adj0), 0);

    for (int i = 0; i < NV; i++) begin
      run(1'b1, int'(VEC[i][17:10]), int'(VEC[i][9]), int'(VEC[i][8:0]), 0);
    end

    // R9: start pulse in the middle of a search
    run(1'b1, 128, 1, 140, 10);
    run(1'b1, 60, 0, 20, 7);

    // R10: narrow variant, rail at 127 and a normal upward search
    run(1'b0, 120, 0, 200, 0);
    run(1'b0, 10, 1, 50, 0);
    run(1'b0, 127, 0, 128, 0);

    // R6: rail and flip on the same sample, downward
    run(1'b1, 2, 0, 1, 0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule